// File: doc/BRIEF.md
# Next-Address Unit with Branch Condition Checker

This block chooses the address of the next instruction in a processor that completes one instruction per cycle. It works only on word addresses. The low two bits of every program counter it produces are zero, and the low two bits of any byte address it receives are ignored. The 30-bit word part of the current PC goes into a single adder with a carry-in of one. The other adder operand is the sign-extended 16-bit immediate when a branch condition holds, and zero when it does not. The same sum therefore gives both the sequential address and the branch target.

A small checker evaluates the branch condition from the two register operands and a 2-bit branch kind. A four-way selector then picks one of four values:

- the adder sum;
- a jump target, made from the top four bits of the PC and the 26-bit target field;
- a register operand with its low bits dropped;
- a fixed trap-entry address, set by a parameter.

The adder sum is also output as the link address. A jump-and-link instruction writes this value to its return register. The block is purely combinational. The PC register, instruction fetch and the register file sit outside it.

Top module: `nal_next_addr`

## Requirements
- R1: Branch kind 0 (`2'b00`) is never taken, even when the register operands are equal. With PC source 0 the next PC is then PC+4.
- R2: Branch kind 1 (`2'b01`) is taken exactly when the two 32-bit register operands are equal.
- R3: Branch kind 2 (`2'b10`) is taken exactly when the two register operands differ.
- R4: Branch kind 3 (`2'b11`) is taken exactly when bit 31 of the first register operand is 1. The second operand plays no part.
- R5: A taken branch with PC source 0 gives the next PC as PC + 4 + 4×(the 16-bit immediate as a signed number). This holds for both forward and backward offsets, up to the most negative value, 16'h8000.
- R6: PC source 1 (`2'b01`) gives a next PC of {PC[31:28], target[25:0], 2'b00}.
- R7: PC source 2 (`2'b10`) gives a next PC of {rs[31:2], 2'b00}. The low two bits of that operand are discarded.
- R8: PC source 3 (`2'b11`) gives a next PC of {SYSCALL_WA, 2'b00}. The default SYSCALL_WA is 30'h2000_0000, which makes the byte address 32'h8000_0000.
- R9: The link output always carries the adder sum, whatever the PC source. It is PC+4 when no branch is taken and the branch target when one is taken.
- R10: All address arithmetic wraps modulo 2^32 bytes. PC 32'hFFFF_FFFC steps to 0, and a backward branch from 0 lands at the top of the address space.
- R11: Bits 1:0 of both outputs are always zero, and bits 1:0 of the PC input have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pc_i | input | 32 | Current program counter (byte address) |
| imm_i | input | 16 | Branch offset in words, two's complement |
| jtarget_i | input | 26 | Jump target field in words |
| rs_val_i | input | 32 | First register operand (comparison, sign test, register jump) |
| rt_val_i | input | 32 | Second register operand (comparison) |
| br_kind_i | input | 2 | 0 none, 1 equal, 2 not equal, 3 negative |
| pc_sel_i | input | 2 | 0 adder, 1 jump target, 2 register, 3 trap entry |
| next_pc_o | output | 32 | Next program counter |
| link_pc_o | output | 32 | Adder sum used as the return address |

## Verification
The branch checker and the source selector act in the same cycle. A taken branch condition can therefore coincide with a PC source that is not the adder. The bench provokes this by applying an equal-operand branch kind together with a jump selection. It expects the next PC to follow the jump target while the link output shows the branch-adjusted sum. A second case raises a negative-operand test together with a register jump, and checks that the two outputs split in the same way.

// File: rtl/nal_pkg.sv
package nal_pkg;

   // branch condition kinds; the encoding is decoded by the branch checker
   typedef enum logic [1:0] {
      BR_NONE = 2'b00,
      BR_EQ   = 2'b01,
      BR_NE   = 2'b10,
      BR_NEG  = 2'b11
   } br_kind_e;

   // next-address sources, in selector order
   typedef enum logic [1:0] {
      SRC_SEQ  = 2'b00,
      SRC_JUMP = 2'b01,
      SRC_REG  = 2'b10,
      SRC_TRAP = 2'b11
   } pc_src_e;

endpackage

// File: rtl/nal_branch_check.sv
module nal_branch_check
   import nal_pkg::*;
#(
   parameter int REG_W = 32
) (
   input  logic [REG_W-1:0] a_i,
   input  logic [REG_W-1:0] b_i,
   input  br_kind_e         kind_i,
   output logic             taken_o
);

   localparam int SIGN_BIT = REG_W - 1;

   if (REG_W < 2) begin : g_bad_width
      $error("nal_branch_check: REG_W must be at least 2");
   end

   logic same;
   logic neg;

   assign same = (a_i == b_i);
   assign neg  = a_i[SIGN_BIT];

   always_comb begin
      unique case (kind_i)
         BR_NONE: taken_o = 1'b0;
         BR_EQ:   taken_o = same;
         BR_NE:   taken_o = !same;
         BR_NEG:  taken_o = neg;
         default: taken_o = 1'b0;
      endcase
   end

   // R1: the no-branch kind never yields a taken condition
   always_comb begin
      a_r1_none_never_taken: assert (!((kind_i == BR_NONE) && taken_o));
   end

   // R4: the sign test depends only on the top bit of the first operand
   always_comb begin
      if (kind_i == BR_NEG) begin
         a_r4_sign_test: assert (taken_o == a_i[SIGN_BIT]);
      end
   end

   // R2 / R3: equality kinds are complementary for the same operands
   always_comb begin
      if (kind_i == BR_EQ && a_i != b_i) begin
         a_r2_eq_mismatch: assert (!taken_o);
      end
      if (kind_i == BR_NE && a_i == b_i) begin
         a_r3_ne_match: assert (!taken_o);
      end
   end

endmodule

// File: rtl/nal_word_adder.sv
module nal_word_adder #(
   parameter int W      = 30,
   parameter bit RIPPLE = 1'b0
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         cin_i,
   output logic [W-1:0] sum_o
);

   if (W < 1) begin : g_bad_width
      $error("nal_word_adder: W must be positive");
   end

   if (RIPPLE) begin : g_ripple
      logic [W:0] carry;
      assign carry[0] = cin_i;
      for (genvar i = 0; i < W; i++) begin : g_bit
         assign sum_o[i]     = a_i[i] ^ b_i[i] ^ carry[i];
         assign carry[i + 1] = (a_i[i] & b_i[i]) | (carry[i] & (a_i[i] ^ b_i[i]));
      end
   end else begin : g_infer
      assign sum_o = a_i + b_i + W'(cin_i);
   end

endmodule

// File: rtl/nal_src_select.sv
module nal_src_select
   import nal_pkg::*;
#(
   parameter int W = 30
) (
   input  pc_src_e      sel_i,
   input  logic [W-1:0] seq_i,
   input  logic [W-1:0] jump_i,
   input  logic [W-1:0] reg_i,
   input  logic [W-1:0] trap_i,
   output logic [W-1:0] out_o
);

   always_comb begin
      unique case (sel_i)
         SRC_SEQ:  out_o = seq_i;
         SRC_JUMP: out_o = jump_i;
         SRC_REG:  out_o = reg_i;
         SRC_TRAP: out_o = trap_i;
         default:  out_o = seq_i;
      endcase
   end

   // R8: the trap source passes the fixed vector untouched
   always_comb begin
      if (sel_i == SRC_TRAP) begin
         a_r8_trap_vector: assert (out_o == trap_i);
      end
   end

endmodule

// File: rtl/nal_next_addr.sv
module nal_next_addr
   import nal_pkg::*;
#(
   parameter int                               ADDR_W       = 32,
   parameter int                               ALIGN_W      = 2,
   parameter int                               IMM_W        = 16,
   parameter int                               JT_W         = 26,
   parameter logic [ADDR_W-ALIGN_W-1:0]        SYSCALL_WA   = 30'h2000_0000,
   parameter bit                               ADDER_RIPPLE = 1'b0
) (
   input  logic [ADDR_W-1:0] pc_i,
   input  logic [IMM_W-1:0]  imm_i,
   input  logic [JT_W-1:0]   jtarget_i,
   input  logic [ADDR_W-1:0] rs_val_i,
   input  logic [ADDR_W-1:0] rt_val_i,
   input  logic [1:0]        br_kind_i,
   input  logic [1:0]        pc_sel_i,
   output logic [ADDR_W-1:0] next_pc_o,
   output logic [ADDR_W-1:0] link_pc_o
);

   localparam int WA_W  = ADDR_W - ALIGN_W;   // word-address width
   localparam int EXT_W = WA_W - IMM_W;       // sign-extension bits
   localparam int HI_W  = WA_W - JT_W;        // PC bits kept on a jump

   if (ALIGN_W < 0 || ALIGN_W >= ADDR_W) begin : g_bad_align
      $error("nal_next_addr: ALIGN_W out of range");
   end
   if (IMM_W < 1 || IMM_W > WA_W) begin : g_bad_imm
      $error("nal_next_addr: IMM_W must fit the word address");
   end
   if (JT_W < 1 || JT_W >= WA_W) begin : g_bad_jt
      $error("nal_next_addr: JT_W must be narrower than the word address");
   end

   logic [WA_W-1:0] pc_word;
   logic [WA_W-1:0] offset_ext;
   logic [WA_W-1:0] addend;
   logic [WA_W-1:0] sum_word;
   logic [WA_W-1:0] jump_word;
   logic [WA_W-1:0] reg_word;
   logic [WA_W-1:0] sel_word;
   logic            taken;
   br_kind_e        kind;
   pc_src_e         src;

   assign pc_word  = pc_i[ADDR_W-1:ALIGN_W];
   assign reg_word = rs_val_i[ADDR_W-1:ALIGN_W];
   assign kind     = br_kind_e'(br_kind_i);
   assign src      = pc_src_e'(pc_sel_i);

   if (EXT_W > 0) begin : g_sext
      assign offset_ext = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
   end else begin : g_nosext
      assign offset_ext = imm_i;
   end

   assign addend    = taken ? offset_ext : '0;
   assign jump_word = {pc_word[WA_W-1:JT_W], jtarget_i};

   nal_branch_check #(
      .REG_W (ADDR_W)
   ) u_check (
      .a_i     (rs_val_i),
      .b_i     (rt_val_i),
      .kind_i  (kind),
      .taken_o (taken)
   );

   nal_word_adder #(
      .W      (WA_W),
      .RIPPLE (ADDER_RIPPLE)
   ) u_adder (
      .a_i   (pc_word),
      .b_i   (addend),
      .cin_i (1'b1),
      .sum_o (sum_word)
   );

   nal_src_select #(
      .W (WA_W)
   ) u_select (
      .sel_i  (src),
      .seq_i  (sum_word),
      .jump_i (jump_word),
      .reg_i  (reg_word),
      .trap_i (SYSCALL_WA),
      .out_o  (sel_word)
   );

   if (ALIGN_W > 0) begin : g_align
      assign next_pc_o = {sel_word, {ALIGN_W{1'b0}}};
      assign link_pc_o = {sum_word, {ALIGN_W{1'b0}}};
   end else begin : g_noalign
      assign next_pc_o = sel_word;
      assign link_pc_o = sum_word;
   end

   // R11: outputs are word aligned
   always_comb begin
      a_r11_aligned: assert (next_pc_o[ALIGN_W-1:0] == '0 && link_pc_o[ALIGN_W-1:0] == '0);
   end

   // R9: sequential source makes next PC and link agree
   always_comb begin
      if (src == SRC_SEQ) begin
         a_r9_seq_link: assert (next_pc_o == link_pc_o);
      end
   end

   // R1 / R9: with no taken branch the link is one word past the PC
   always_comb begin
      if (!taken) begin
         a_r9_plain_increment: assert (link_pc_o[ADDR_W-1:ALIGN_W] == WA_W'(pc_word + 1'b1));
      end
   end

   // R6: a jump keeps the upper PC bits
   always_comb begin
      if (src == SRC_JUMP) begin
         a_r6_jump_region: assert (next_pc_o[ADDR_W-1:ADDR_W-HI_W] == pc_i[ADDR_W-1:ADDR_W-HI_W]);
      end
   end

   // R7: a register jump carries the operand's upper bits
   always_comb begin
      if (src == SRC_REG) begin
         a_r7_reg_jump: assert (next_pc_o[ADDR_W-1:ALIGN_W] == rs_val_i[ADDR_W-1:ALIGN_W]);
      end
   end

endmodule

// File: tb/nal_next_addr_test.sv
module nal_next_addr_test;

   typedef struct packed {
      logic [23:0] tag;
      logic [31:0] pc;
      logic [15:0] imm;
      logic [25:0] jt;
      logic [31:0] rs;
      logic [31:0] rt;
      logic [1:0]  kind;
      logic [1:0]  sel;
      logic [31:0] exp_next;
      logic [31:0] exp_link;
   } vec_t;

   localparam int NV = 16;

   localparam vec_t VEC [NV] = '{
      // R1: kind 0 with equal operands stays sequential
      '{" R1", 32'h0000_1000, 16'h0010, 26'h0, 32'h5, 32'h5, 2'd0, 2'd0, 32'h0000_1004, 32'h0000_1004},
      // R2: equal, taken forward
      '{" R2", 32'h0000_1000, 16'h0010, 26'h0, 32'h7, 32'h7, 2'd1, 2'd0, 32'h0000_1044, 32'h0000_1044},
      // R2: unequal, not taken
      '{" R2", 32'h0000_1000, 16'h0010, 26'h0, 32'h7, 32'h8, 2'd1, 2'd0, 32'h0000_1004, 32'h0000_1004},
      // R3: differ, taken backward
      '{" R3", 32'h0000_1000, 16'hFFFE, 26'h0, 32'h1, 32'h2, 2'd2, 2'd0, 32'h0000_0FFC, 32'h0000_0FFC},
      // R3: same, not taken
      '{" R3", 32'h0000_1000, 16'hFFFE, 26'h0, 32'h3, 32'h3, 2'd2, 2'd0, 32'h0000_1004, 32'h0000_1004},
      // R4: negative rs taken, largest forward offset
      '{" R4", 32'h0040_0000, 16'h7FFF, 26'h0, 32'h8000_0000, 32'h1, 2'd3, 2'd0, 32'h0042_0000, 32'h0042_0000},
      // R4: positive rs not taken
      '{" R4", 32'h0040_0000, 16'h7FFF, 26'h0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 2'd3, 2'd0, 32'h0040_0004, 32'h0040_0004},
      // R5: most negative offset
      '{" R5", 32'h0002_0000, 16'h8000, 26'h0, 32'h0, 32'h0, 2'd1, 2'd0, 32'h0000_0004, 32'h0000_0004},
      // R10: sequential wrap at top of space
      '{"R10", 32'hFFFF_FFFC, 16'h0000, 26'h0, 32'h0, 32'h1, 2'd0, 2'd0, 32'h0000_0000, 32'h0000_0000},
      // R10: backward branch below zero
      '{"R10", 32'h0000_0000, 16'hFFFE, 26'h0, 32'h9, 32'h9, 2'd1, 2'd0, 32'hFFFF_FFFC, 32'hFFFF_FFFC},
      // R6: jump keeps PC[31:28]
      '{" R6", 32'hA123_4568, 16'h0000, 26'h3FF_FFFF, 32'h0, 32'h1, 2'd0, 2'd1, 32'hAFFF_FFFC, 32'hA123_456C},
      // R7: register jump drops low bits
      '{" R7", 32'h0000_0100, 16'h0000, 26'h0, 32'h1234_5677, 32'h0, 2'd0, 2'd2, 32'h1234_5674, 32'h0000_0104},
      // R8: trap vector
      '{" R8", 32'h0000_0200, 16'h0000, 26'h0, 32'h0, 32'h1, 2'd0, 2'd3, 32'h8000_0000, 32'h0000_0204},
      // R9: taken branch while jump selected: link shows the branch sum
      '{" R9", 32'h0000_1000, 16'h0010, 26'h000_0040, 32'h4, 32'h4, 2'd1, 2'd1, 32'h0000_0100, 32'h0000_1044},
      // R9: negative test taken while register jump selected
      '{" R9", 32'h0000_2000, 16'h0004, 26'h0, 32'hF000_0008, 32'h0, 2'd3, 2'd2, 32'hF000_0008, 32'h0000_2014},
      // R11: low PC bits ignored
      '{"R11", 32'h0000_1003, 16'h0000, 26'h0, 32'h0, 32'h1, 2'd0, 2'd0, 32'h0000_1004, 32'h0000_1004}
   };

   logic        clk = 1'b0;
   logic [31:0] pc_i = '0;
   logic [15:0] imm_i = '0;
   logic [25:0] jtarget_i = '0;
   logic [31:0] rs_val_i = '0;
   logic [31:0] rt_val_i = '0;
   logic [1:0]  br_kind_i = '0;
   logic [1:0]  pc_sel_i = '0;
   logic [31:0] next_pc_o;
   logic [31:0] link_pc_o;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   nal_next_addr uut (
      .pc_i      (pc_i),
      .imm_i     (imm_i),
      .jtarget_i (jtarget_i),
      .rs_val_i  (rs_val_i),
      .rt_val_i  (rt_val_i),
      .br_kind_i (br_kind_i),
      .pc_sel_i  (pc_sel_i),
      .next_pc_o (next_pc_o),
      .link_pc_o (link_pc_o)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic apply(input logic [31:0] pc, input logic [15:0] imm, input logic [25:0] jt,
                        input logic [31:0] rs, input logic [31:0] rt,
                        input logic [1:0] kind, input logic [1:0] sel);
      @(negedge clk);
      pc_i = pc; imm_i = imm; jtarget_i = jt;
      rs_val_i = rs; rt_val_i = rt; br_kind_i = kind; pc_sel_i = sel;
      @(posedge clk);
      #1;
   endtask

   initial begin
      // reset-like state: all inputs zero
      apply(32'h0, 16'h0, 26'h0, 32'h0, 32'h0, 2'd0, 2'd0);
      check("R1", "zero-input next", next_pc_o, 32'h0000_0004);
      check("R9", "zero-input link", link_pc_o, 32'h0000_0004);

      for (int i = 0; i < NV; i++) begin
         apply(VEC[i].pc, VEC[i].imm, VEC[i].jt, VEC[i].rs, VEC[i].rt, VEC[i].kind, VEC[i].sel);
         check(string'(VEC[i].tag), $sformatf("vec %0d next", i), next_pc_o, VEC[i].exp_next);
         check(string'(VEC[i].tag), $sformatf("vec %0d link", i), link_pc_o, VEC[i].exp_link);
      end

      // every kind with rs == rt == 0, offset +1 word
      apply(32'h1000, 16'h0001, 26'h0, 32'h0, 32'h0, 2'd0, 2'd0);
      check("R1", "kind0 zeros", next_pc_o, 32'h0000_1004);
      apply(32'h1000, 16'h0001, 26'h0, 32'h0, 32'h0, 2'd1, 2'd0);
      check("R2", "kind1 zeros", next_pc_o, 32'h0000_1008);
      apply(32'h1000, 16'h0001, 26'h0, 32'h0, 32'h0, 2'd2, 2'd0);
      check("R3", "kind2 zeros", next_pc_o, 32'h0000_1004);
      apply(32'h1000, 16'h0001, 26'h0, 32'h0, 32'h0, 2'd3, 2'd0);
      check("R4", "kind3 zeros", next_pc_o, 32'h0000_1004);
      // R4: rt does not matter for the sign test
      apply(32'h1000, 16'h0001, 26'h0, 32'hFFFF_FFFF, 32'h1234_0000, 2'd3, 2'd0);
      check("R4", "kind3 rt ignored", next_pc_o, 32'h0000_1008);
      // R8: trap vector independent of PC
      apply(32'hFFFF_FFF0, 16'h0003, 26'h155_5555, 32'h0, 32'h0, 2'd1, 2'd3);
      check("R8", "trap next", next_pc_o, 32'h8000_0000);
      check("R9", "trap link with taken", link_pc_o, 32'h0000_0000);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule